// File: doc/BRIEF.md
# Serial Write-Only Configuration Register Port

This block is the slave side of a three-wire serial control link through which a host loads a bank of 8-bit configuration registers. The host drives an active-low select, a serial clock and a serial data line, all inputs to the block. The block has no data output toward the host. Each transfer opens with a header byte that holds a 7-bit device address and a direction flag. A pointer byte follows, and then one or more data bytes are written into the register bank.

The three serial inputs are brought into the system clock domain through a synchronizer chain. Rising serial-clock edges are then detected on the system clock, so a running system clock is required. Host activity needs no fixed relation to any other timing in the chip. Every completed data byte raises a one-cycle write strobe together with the target address and the byte. The full register bank is also presented as a flat vector, for the rest of the chip to consume.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset every register reads 0x00, and the write strobe is low.
- R2: A frame whose header carries device address 7'h10 and a direction flag of 0 writes each following data byte into the register the pointer selects. Bits are taken MSB first on rising serial-clock edges while select is low. The header sends the address in bits 7:1 and the direction flag in bit 0.
- R3: When the header address differs from 7'h10, the remainder of the frame changes no register and raises no strobe.
- R4: When the header's direction flag is 1, the remainder of the frame changes no register and raises no strobe.
- R5: When bit 7 of the pointer byte is 0, all data bytes of the frame go to the register given by pointer bits 6:0. The last byte is the one that remains.
- R6: When bit 7 of the pointer byte is 1, the pointer advances by one after each data byte is written.
- R7: During auto-advance, the pointer wraps from register 127 to register 0.
- R8: Raising select at any point ends the frame and discards any partly received byte. The next frame starts again from its header.
- R9: Each completed data byte produces exactly one write strobe, one system-clock cycle wide, carrying that byte's register address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from host |
| sclk | input | 1 | Serial bit clock from host |
| sdi | input | 1 | Serial data from host |
| wr_stb | output | 1 | One-cycle write strobe per data byte |
| wr_addr | output | 7 | Register address of the current write |
| wr_data | output | 8 | Data byte of the current write |
| cfg_regs | output | 1024 | Register bank, register n at bits n*8+7:n*8 |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 7-bit register address giving 128 registers, device address 7'h10 and two synchronizer stages. With the bank this small, random pointers reach the top register often, and a directed burst that starts at register 126 crosses the wrap to register 0. The serial clock runs slowly against the system clock, so select edges can be placed mid-byte and inside the header, which exercises the abort paths.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_PTR  = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;
endpackage

// File: rtl/spi_cfg_rst_sync.sv
module spi_cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'h10,
  localparam int               ADDR_W   = DATA_W - 1,
  localparam int               CNT_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  phase_e              phase_q, phase_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [DATA_W-1:0]   shreg_q, shreg_d;
  logic [ADDR_W-1:0]   ptr_q, ptr_d;
  logic                incr_q, incr_d;
  logic                stb_q, stb_d;
  logic [ADDR_W-1:0]   waddr_q, waddr_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic                sclk_prev_q;
  logic                bit_rise;
  logic                byte_done;
  logic [DATA_W-1:0]   byte_nxt;

  assign bit_rise  = sclk_s && !sclk_prev_q;
  assign byte_nxt  = {shreg_q[DATA_W-2:0], sdi_s};
  assign byte_done = bit_rise && (cnt_q == CNT_W'(DATA_W-1));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    ptr_d   = ptr_q;
    incr_d  = incr_q;
    stb_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    if (!cs_act) begin
      phase_d = PH_HDR;
      cnt_d   = '0;
    end else if (bit_rise && phase_q != PH_SKIP) begin
      shreg_d = byte_nxt;
      cnt_d   = byte_done ? '0 : cnt_q + 1'b1;
      if (byte_done) begin
        unique case (phase_q)
          PH_HDR: begin
            if (byte_nxt[DATA_W-1:1] == DEV_ADDR && !byte_nxt[0]) phase_d = PH_PTR;
            else                                                  phase_d = PH_SKIP;
          end
          PH_PTR: begin
            incr_d  = byte_nxt[DATA_W-1];
            ptr_d   = byte_nxt[ADDR_W-1:0];
            phase_d = PH_DATA;
          end
          PH_DATA: begin
            stb_d   = 1'b1;
            waddr_d = ptr_q;
            wdata_d = byte_nxt;
            if (incr_q) ptr_d = ptr_q + 1'b1;
          end
          default: phase_d = PH_SKIP;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_HDR;
      cnt_q       <= '0;
      shreg_q     <= '0;
      ptr_q       <= '0;
      incr_q      <= 1'b0;
      stb_q       <= 1'b0;
      waddr_q     <= '0;
      wdata_q     <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      cnt_q       <= cnt_d;
      shreg_q     <= shreg_d;
      ptr_q       <= ptr_d;
      incr_q      <= incr_d;
      stb_q       <= stb_d;
      waddr_q     <= waddr_d;
      wdata_q     <= wdata_d;
      sclk_prev_q <= sclk_s;
    end
  end

  assign wr_stb  = stb_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  // R3
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(phase_q) == PH_DATA);

  // R8
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase_q == PH_HDR && cnt_q == '0 && !stb_q));

  // R6 R7
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && incr_q) |-> ptr_q == ADDR_W'(waddr_q + 1'b1));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && !incr_q) |-> ptr_q == waddr_q);
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank #(
  parameter int  DATA_W = 8,
  parameter int  ADDR_W = 7,
  localparam int NREG   = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (wr_addr == ADDR_W'(i)) regs_q[i] <= wr_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
  end

  // R2
  bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port #(
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR    = 7'h10,
  parameter int                SYNC_STAGES = 2,
  localparam int               ADDR_W      = DATA_W - 1,
  localparam int               NREG        = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   wr_stb,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] cfg_regs
);
  logic       rst_n_s;
  logic [2:0] pins_s;

  spi_cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  spi_cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   ({cs_n, sclk, sdi}),
    .dout  (pins_s)
  );

  spi_cfg_frame #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cs_act  (!pins_s[2]),
    .sclk_s  (pins_s[1]),
    .sdi_s   (pins_s[0]),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  spi_cfg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .regs_flat (cfg_regs)
  );
endmodule

// File: tb/tb_spi_cfg_port.sv
module tb_spi_cfg_port;
  localparam int NREG = 128;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  wire              wr_stb;
  wire [6:0]        wr_addr;
  wire [7:0]        wr_data;
  wire [NREG*8-1:0] cfg_regs;

  always #4 clk = ~clk;

  spi_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .cfg_regs(cfg_regs)
  );

  logic [7:0] model [NREG];
  logic [6:0] exp_a [1024];
  logic [7:0] exp_d [1024];
  logic [7:0] dbuf [8];
  int exp_n = 0;
  int checks = 0;
  int fails = 0;
  int stb_n = 0;
  int mon_checks = 0;
  int mon_fails = 0;
  logic stb_prev = 1'b0;

  // R9: every strobe compared against the expected write list
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      mon_checks = mon_checks + 1;
      if (stb_n >= exp_n) begin
        mon_fails = mon_fails + 1;
        $display("FAIL R9 unexpected strobe addr=%0h data=%0h expected none", wr_addr, wr_data);
      end else begin
        if (wr_addr !== exp_a[stb_n] || wr_data !== exp_d[stb_n]) begin
          mon_fails = mon_fails + 1;
          $display("FAIL R9 strobe addr=%0h data=%0h expected addr=%0h data=%0h",
                   wr_addr, wr_data, exp_a[stb_n], exp_d[stb_n]);
        end
      end
      stb_n = stb_n + 1;
      if (stb_prev) begin
        mon_fails = mon_fails + 1;
        $display("FAIL R9 strobe width actual=2+ expected=1");
      end
    end
    stb_prev = wr_stb;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk) sdi = b;
    repeat (HALF) @(posedge clk);
    @(negedge clk) sclk = 1'b1;
    repeat (HALF) @(posedge clk);
    @(negedge clk) sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) put_bit(b[7-i]);
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(posedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(posedge clk);
    @(negedge clk) cs_n = 1'b1;
    repeat (20) @(posedge clk);
  endtask

  task automatic frame_run(input logic [6:0] dev, input logic rw, input logic [7:0] ptrb,
                           input int nbytes, input int tail_bits);
    logic [6:0] p;
    cs_low();
    send_bits({dev, rw}, 8);
    send_bits(ptrb, 8);
    p = ptrb[6:0];
    for (int i = 0; i < nbytes; i++) begin
      if (dev == 7'h10 && !rw) begin
        exp_a[exp_n] = p;
        exp_d[exp_n] = dbuf[i];
        exp_n = exp_n + 1;
        model[p] = dbuf[i];
        if (ptrb[7]) p = p + 7'd1;
      end
      send_bits(dbuf[i], 8);
    end
    if (tail_bits > 0) send_bits(8'hC3, tail_bits);
    cs_high();
  endtask

  task automatic check_state(input string req);
    int bad;
    int first;
    bad = 0;
    first = -1;
    for (int i = 0; i < NREG; i++)
      if (cfg_regs[i*8 +: 8] !== model[i]) begin
        bad = bad + 1;
        if (first < 0) first = i;
      end
    if (first < 0) check(1'b1, req, "bank", 0, 0);
    else check(1'b0, req, "bank reg", int'(cfg_regs[first*8 +: 8]), int'(model[first]));
    check(stb_n == exp_n, req, "strobe count", stb_n, exp_n);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (10) @(posedge clk);

    // R1: reset state
    @(negedge clk);
    check(wr_stb == 1'b0, "R1", "wr_stb", int'(wr_stb), 0);
    check_state("R1");

    // R2: single write, MSB first (0x01 must not appear as 0x80)
    dbuf[0] = 8'h01;
    frame_run(7'h10, 1'b0, 8'h05, 1, 0);
    check(cfg_regs[5*8 +: 8] == 8'h01, "R2", "reg5", int'(cfg_regs[5*8 +: 8]), 1);
    dbuf[0] = 8'hA5;
    frame_run(7'h10, 1'b0, 8'h06, 1, 0);
    check_state("R2");

    // R3: wrong device address
    dbuf[0] = 8'hFF; dbuf[1] = 8'hEE;
    frame_run(7'h11, 1'b0, 8'h05, 2, 0);
    check(cfg_regs[5*8 +: 8] == 8'h01, "R3", "reg5 untouched", int'(cfg_regs[5*8 +: 8]), 1);
    check_state("R3");

    // R4: read flag set
    frame_run(7'h10, 1'b1, 8'h05, 2, 0);
    check_state("R4");

    // R5: fixed pointer, last byte stays
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
    frame_run(7'h10, 1'b0, 8'h20, 3, 0);
    check(cfg_regs[32*8 +: 8] == 8'h33, "R5", "reg20", int'(cfg_regs[32*8 +: 8]), 8'h33);
    check(cfg_regs[33*8 +: 8] == 8'h00, "R5", "reg21", int'(cfg_regs[33*8 +: 8]), 0);
    check_state("R5");

    // R6: auto-advance burst
    dbuf[0] = 8'h44; dbuf[1] = 8'h55; dbuf[2] = 8'h66;
    frame_run(7'h10, 1'b0, 8'hC0, 3, 0);
    check(cfg_regs[66*8 +: 8] == 8'h66, "R6", "reg42", int'(cfg_regs[66*8 +: 8]), 8'h66);
    check_state("R6");

    // R7: wrap 126,127,0,1
    dbuf[0] = 8'h7E; dbuf[1] = 8'h7F; dbuf[2] = 8'h80; dbuf[3] = 8'h81;
    frame_run(7'h10, 1'b0, 8'hFE, 4, 0);
    check(cfg_regs[0 +: 8] == 8'h80, "R7", "reg0", int'(cfg_regs[0 +: 8]), 8'h80);
    check_state("R7");

    // R8: abort mid data byte
    dbuf[0] = 8'h5A;
    frame_run(7'h10, 1'b0, 8'h90, 1, 5);
    check(cfg_regs[17*8 +: 8] == 8'h00, "R8", "reg11 after abort", int'(cfg_regs[17*8 +: 8]), 0);
    check_state("R8");

    // R8: abort inside header, then a fresh frame
    cs_low();
    send_bits(8'h20, 4);
    cs_high();
    dbuf[0] = 8'h3C;
    frame_run(7'h10, 1'b0, 8'h09, 1, 0);
    check(cfg_regs[9*8 +: 8] == 8'h3C, "R8", "reg9 after header abort", int'(cfg_regs[9*8 +: 8]), 8'h3C);
    check_state("R8");

    // R2 R5 R6 R7 R9: random frames
    for (int f = 0; f < 40; f++) begin
      logic [6:0] dev;
      logic rw;
      logic [7:0] ptrb;
      int nb;
      dev  = ($urandom % 5 == 0) ? 7'($urandom) : 7'h10;
      rw   = ($urandom % 6 == 0);
      ptrb = 8'($urandom);
      nb   = 1 + ($urandom % 4);
      for (int k = 0; k < nb; k++) dbuf[k] = 8'($urandom);
      frame_run(dev, rw, ptrb, nb, ($urandom % 3 == 0) ? 3 : 0);
      check_state("R9");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule